// File: doc/BRIEF.md
# Solid-Pattern March Test Sequencer

This block runs a four-pass march over a single-port RAM and reports every failing word. It fills the array with all-ones, reads the array back, fills it with all-zeros, then reads it back again. Each pass visits every address once, in ascending order, one access per clock.

The RAM returns read data one cycle after the read strobe. A comparator checks that data against the value the current pass expects. When a word differs, the sequencer stops and raises a fault flag, with the row and column of the failing word on the fault outputs. It then waits for a redundancy analyzer to send a one-cycle resume pulse before it continues.

A start pulse launches a run from idle. The busy output covers the whole run, including the time spent stopped on a fault. A one-cycle done pulse marks the end of the run.

Top module: `march_bist`

## Requirements
- R1: While reset is high and in the first cycle after it, both strobes, test_done, test_busy and fault_hit are all 0.
- R2: In idle, nothing happens while start is 0. The cycle after start is seen high in idle carries a write strobe to address 0.
- R3: The four passes run in this order: fill with ones, read ones, fill with zeros, read zeros. Each pass makes one access per cycle at addresses 0 to 2^(ROW_W+COL_W)-1 in ascending order. mem_addr is {row, col}, with the row in the upper ROW_W bits. mem_we and mem_re are never high together.
- R4: Every write in the first fill carries all-ones data. Every write in the second fill carries all-zeros data.
- R5: Read data is taken from mem_rdata in the cycle after mem_re. It is compared with all-ones during the first read pass and with all-zeros during the second.
- R6: If any bit differs, fault_hit rises at the next clock edge, and fault_row and fault_col hold the failing word's row and column. Several wrong bits in one word give one report. Any read issued in the same cycle as the failing comparison is discarded.
- R7: While fault_hit is high, both strobes stay low and fault_hit stays high until a resume pulse arrives. In the cycle after resume, fault_hit is 0 and the sequencer repeats the access to the address after the failing one. Resume has no effect at any other time.
- R8: After the last comparison, test_done is high for exactly one cycle, and the block then returns to idle. test_busy is 1 from the cycle after start until test_done rises, and it is 0 while test_done is high.
- R9: A start pulse during a run has no effect.
- R10: A failing word at the last address of a read pass is reported in the same way. This holds when its comparison falls in the first cycle of the next pass, or just before the end of the run. In the second case test_done comes only after the resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run from idle |
| resume | input | 1 | One-cycle pulse from the analyzer to leave the fault stop |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_addr | output | ROW_W+COL_W | RAM word address {row, col} |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after mem_re |
| test_done | output | 1 | One-cycle end-of-run pulse |
| test_busy | output | 1 | Run in progress |
| fault_hit | output | 1 | Fault present; the sequencer is stopped |
| fault_row | output | ROW_W | Row of the failing word |
| fault_col | output | COL_W | Column of the failing word |

## Verification
The march is driven against a RAM model with stuck-at bits placed to separate distinct behaviours:
- A clean array checks pass order, addressing and the done timing. A start and a resume pulse sent mid-run must leave the run unchanged.
- A stuck-at-0 bit and a stuck-at-1 bit at different addresses show that each read pass compares against its own expected value.
- Two adjacent failing words show that the in-flight read is discarded and then repeated after resume.
- Faults on the last word check reports whose comparison falls after the pass has already moved on.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FILL1  = 3'd1,
        PH_SCAN1  = 3'd2,
        PH_FILL0  = 3'd3,
        PH_SCAN0  = 3'd4,
        PH_FINISH = 3'd5,
        PH_HOLD   = 3'd6
    } phase_e;

    // Tag travelling alongside a read that is in flight to the RAM
    typedef struct packed {
        logic live;
        logic ones;
    } rd_tag_t;

    function automatic logic ph_writes(phase_e p);
        return (p == PH_FILL1) || (p == PH_FILL0);
    endfunction

    function automatic logic ph_reads(phase_e p);
        return (p == PH_SCAN1) || (p == PH_SCAN0);
    endfunction

    function automatic logic ph_sweeps(phase_e p);
        return ph_writes(p) || ph_reads(p);
    endfunction

    function automatic logic ph_ones(phase_e p);
        return (p == PH_FILL1) || (p == PH_SCAN1);
    endfunction

    function automatic phase_e ph_after(phase_e p);
        case (p)
            PH_FILL1: return PH_SCAN1;
            PH_SCAN1: return PH_FILL0;
            PH_FILL0: return PH_SCAN0;
            PH_SCAN0: return PH_FINISH;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/march_addr_ctr.sv
module march_addr_ctr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (step)
            addr <= addr + ONE;   // wraps to zero after the top word
    end

    assign at_end = &addr;

endmodule

// File: rtl/march_resp_chk.sv
module march_resp_chk
    import march_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic          issue_ones,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] rdata,
    output logic          pending,
    output logic          mismatch,
    output logic [AW-1:0] bad_addr
);
    rd_tag_t       tag_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] expect_w;

    assign expect_w = {DW{tag_q.ones}};
    assign mismatch = tag_q.live && (rdata != expect_w);
    assign pending  = tag_q.live;
    assign bad_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '{live: 1'b0, ones: 1'b0};
            addr_q <= '0;
        end else begin
            // a read issued while a failure is being flagged is dropped
            tag_q.live <= issue && !mismatch;
            tag_q.ones <= issue_ones;
            addr_q     <= issue_addr;
        end
    end

endmodule

// File: rtl/march_fsm.sv
module march_fsm
    import march_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   resume,
    input  logic   at_end,
    input  logic   pending,
    input  logic   mismatch,
    output phase_e phase,
    output logic   step,
    output logic   done,
    output logic   busy
);
    phase_e ph_q, ph_d, park_q;

    always_comb begin
        ph_d = ph_q;
        if (mismatch) begin
            ph_d = PH_HOLD;
        end else begin
            case (ph_q)
                PH_IDLE:   if (start) ph_d = PH_FILL1;
                PH_FILL1,
                PH_SCAN1,
                PH_FILL0,
                PH_SCAN0:  if (at_end) ph_d = ph_after(ph_q);
                PH_FINISH: if (!pending) ph_d = PH_IDLE;
                PH_HOLD:   if (resume) ph_d = park_q;
                default:   ph_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            park_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
            if (mismatch)
                park_q <= ph_q;
        end
    end

    assign phase = ph_q;
    assign step  = ph_sweeps(ph_q) && !mismatch;
    assign done  = (ph_q == PH_FINISH) && !pending;
    assign busy  = (ph_q != PH_IDLE) && !done;

endmodule

// File: rtl/march_fault_reg.sv
module march_fault_reg #(
    parameter int RW = 4,
    parameter int CW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic            drop,
    input  logic [RW+CW-1:0] bad_addr,
    output logic            flag,
    output logic [RW-1:0]   row,
    output logic [CW-1:0]   col
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            row  <= '0;
            col  <= '0;
        end else if (capture) begin
            flag <= 1'b1;
            row  <= bad_addr[RW+CW-1:CW];
            col  <= bad_addr[CW-1:0];
        end else if (drop) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/march_bist.sv
module march_bist
    import march_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   resume,
    output logic                   mem_we,
    output logic                   mem_re,
    output logic [ROW_W+COL_W-1:0] mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   test_done,
    output logic                   test_busy,
    output logic                   fault_hit,
    output logic [ROW_W-1:0]       fault_row,
    output logic [COL_W-1:0]       fault_col
);
    localparam int AW = ROW_W + COL_W;

    phase_e        phase;
    logic          step, at_end, pending, mismatch;
    logic [AW-1:0] addr, bad_addr;

    march_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .resume   (resume),
        .at_end   (at_end),
        .pending  (pending),
        .mismatch (mismatch),
        .phase    (phase),
        .step     (step),
        .done     (test_done),
        .busy     (test_busy)
    );

    march_addr_ctr #(.AW(AW)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .addr   (addr),
        .at_end (at_end)
    );

    march_resp_chk #(.DW(DATA_W), .AW(AW)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .issue      (mem_re),
        .issue_ones (ph_ones(phase)),
        .issue_addr (addr),
        .rdata      (mem_rdata),
        .pending    (pending),
        .mismatch   (mismatch),
        .bad_addr   (bad_addr)
    );

    march_fault_reg #(.RW(ROW_W), .CW(COL_W)) u_flt (
        .clk      (clk),
        .rst      (rst),
        .capture  (mismatch),
        .drop     ((phase == PH_HOLD) && resume),
        .bad_addr (bad_addr),
        .flag     (fault_hit),
        .row      (fault_row),
        .col      (fault_col)
    );

    assign mem_we    = ph_writes(phase);
    assign mem_re    = ph_reads(phase);
    assign mem_addr  = addr;
    assign mem_wdata = {DATA_W{phase == PH_FILL1}};

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   resume,
    input logic                   mem_we,
    input logic                   mem_re,
    input logic [ROW_W+COL_W-1:0] mem_addr,
    input logic [DATA_W-1:0]      mem_wdata,
    input logic                   test_done,
    input logic                   test_busy,
    input logic                   fault_hit
);
    localparam int AW = ROW_W + COL_W;
    localparam logic [AW-1:0] ONE = AW'(1);

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !test_busy && !test_done && !fault_hit) |=> (mem_we && mem_addr == '0));

    // R3
    sweep_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ONE));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R4
    solid_data_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == '0 || &mem_wdata));

    // R7
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fault_hit |-> (!mem_we && !mem_re && !test_done));

    // R7
    hold_until_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_hit && !resume) |=> fault_hit);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        test_done |=> (!test_done && !test_busy));

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        test_done |-> !test_busy);

endmodule

bind march_bist march_bist_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .resume    (resume),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .test_done (test_done),
    .test_busy (test_busy),
    .fault_hit (fault_hit)
);

// File: tb/march_bist_tb.sv
module march_bist_tb;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int DATA_W = 8;
    localparam int AW     = ROW_W + COL_W;
    localparam int NW     = 1 << AW;
    localparam int LIMIT  = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic resume = 1'b0;
    logic mem_we, mem_re, test_done, test_busy, fault_hit;
    logic [AW-1:0]     mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [ROW_W-1:0]  fault_row;
    logic [COL_W-1:0]  fault_col;

    always #10 clk = ~clk;   // 50 MHz

    march_bist #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .resume(resume),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .test_done(test_done), .test_busy(test_busy),
        .fault_hit(fault_hit), .fault_row(fault_row), .fault_col(fault_col)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // RAM with stuck-at bits
    logic [DATA_W-1:0] ram [NW];
    logic [DATA_W-1:0] sa0 [NW];
    logic [DATA_W-1:0] sa1 [NW];

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= (ram[mem_addr] & ~sa0[mem_addr]) | sa1[mem_addr];
    end

    // Behavioural reference: phase 0 idle, 1..4 passes, 5 finish, 6 stopped
    int m_ph = 0, m_park = 0, m_addr = 0, m_paddr = 0, m_flt_addr = 0;
    bit m_pend = 0, m_pone = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_park = 0; m_addr = 0; m_pend = 0; m_pone = 0;
        end else if (m_pend && mem_rdata != (m_pone ? {DATA_W{1'b1}} : {DATA_W{1'b0}})) begin
            m_flt_addr = m_paddr; m_park = m_ph; m_ph = 6; m_pend = 0;
        end else begin
            bit rd_now;
            rd_now = (m_ph == 2 || m_ph == 4);
            m_pone = (m_ph == 2);
            m_paddr = m_addr;
            case (m_ph)
                0: if (start) m_ph = 1;
                1, 2, 3, 4: begin
                    m_addr = (m_addr + 1) % NW;
                    if (m_addr == 0) m_ph = m_ph + 1;
                end
                5: if (!m_pend) m_ph = 0;
                6: if (resume) m_ph = m_park;
                default: m_ph = 0;
            endcase
            m_pend = rd_now;
        end
    end

    // Compare every cycle on the falling edge
    always @(negedge clk) begin
        bit e_we, e_re, e_done;
        e_we   = (m_ph == 1 || m_ph == 3);
        e_re   = (m_ph == 2 || m_ph == 4);
        e_done = (m_ph == 5 && !m_pend);
        chk("R3 write strobe", mem_we, e_we);
        chk("R5 read strobe", mem_re, e_re);
        if (e_we || e_re) chk("R3 address", mem_addr, m_addr);
        if (e_we) chk("R4 write data", mem_wdata, (m_ph == 1) ? {DATA_W{1'b1}} : '0);
        chk("R8 done", test_done, e_done);
        chk("R8 busy", test_busy, (m_ph != 0) && !e_done);
        chk("R6 fault flag", fault_hit, m_ph == 6);
        if (m_ph == 6) chk("R6 fault address", {fault_row, fault_col}, m_flt_addr);
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    int exp_q[$];

    task automatic clear_faults();
        for (int i = 0; i < NW; i++) begin sa0[i] = '0; sa1[i] = '0; end
    endtask

    task automatic run_march(input string tag, input int hold_cyc, input bit poke);
        int seen[$];
        int guard;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 first write strobe", mem_we, 1);
        chk("R2 first write address", mem_addr, 0);
        guard = 0;
        while (!test_done && guard < 20000) begin
            if (poke && guard == 10) begin
                start = 1'b1; resume = 1'b1;   // R9 and R7: both must be ignored
                @(negedge clk);
                start = 1'b0; resume = 1'b0;
                chk("R9 run continues after stray start", test_busy, 1);
            end else if (fault_hit) begin
                seen.push_back(int'({fault_row, fault_col}));
                for (int k = 0; k < hold_cyc; k++) begin
                    @(negedge clk);
                    chk("R7 stop held", fault_hit, 1);
                    chk("R7 no strobe while stopped", mem_we | mem_re, 0);
                end
                resume = 1'b1;
                @(negedge clk);
                resume = 1'b0;
                chk("R7 flag cleared by resume", fault_hit, 0);
            end else begin
                @(negedge clk);
            end
            guard++;
        end
        chk("R8 run completes", test_done, 1);
        chk({tag, " fault count"}, seen.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < seen.size(); i++)
            chk({tag, " fault position"}, seen[i], exp_q[i]);
        @(negedge clk);
        chk("R8 idle after done", test_busy | test_done, 0);
    endtask

    initial begin
        clear_faults();
        for (int i = 0; i < NW; i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        // R1 state under reset
        chk("R1 strobes in reset", mem_we | mem_re, 0);
        chk("R1 flags in reset", test_done | test_busy | fault_hit, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 flags after reset", test_done | test_busy | fault_hit, 0);
        repeat (4) @(negedge clk);
        chk("R2 idle without start", mem_we | mem_re | test_busy, 0);

        // clean array with stray start/resume
        exp_q = {};
        run_march("R9 clean", 2, 1'b1);

        // stuck-at-0 seen in ones pass, stuck-at-1 seen in zeros pass
        clear_faults();
        sa0[5] = 8'h04; sa1[40] = 8'h80;
        exp_q = {5, 40};
        run_march("R6 mixed stuck", 3, 1'b0);

        // neighbouring failures: in-flight read discarded and reissued
        clear_faults();
        sa0[9] = 8'hFF; sa0[10] = 8'h01;
        exp_q = {9, 10};
        run_march("R7 adjacent", 1, 1'b0);

        // last word fails in both read passes
        clear_faults();
        sa0[NW-1] = 8'h01; sa1[NW-1] = 8'h02;
        exp_q = {NW-1, NW-1};
        run_march("R10 top word", 4, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule